// File: doc/BRIEF.md
# Two-Thread Activity Mode Controller

This block tracks which of the two logical threads of a shared core are running. From that it derives the resource mode that the core's partitioned structures follow. Each thread reports a one-cycle pulse when it executes a halt. Each thread can also receive a one-cycle interrupt pulse. Together these pulses start and stop the thread.

The controller keeps one activity flag per thread. It encodes the pair of flags as a two-bit mode code:

- dual-thread mode
- thread-0-only mode
- thread-1-only mode
- sleep, when no thread runs

A separate split flag tells queues and buffers to divide their entries between the threads. The flag is set only when both threads run. In every other mode the queues give all entries to the one thread that remains.

A halt from a thread that is already stopped has no effect. An interrupt to a thread that is already running also has no effect. A parameter chooses between two output variants: the mode outputs decoded directly from the activity flops, or the mode outputs held in their own register stage.

Top module: `smt_mode_ctrl`

## Requirements
- R1: After reset, both activity flags are 1, the mode code is 2'b00 (dual) and the split flag is 1.
- R2: In dual mode, a halt pulse on thread 1 alone gives mode 2'b01 (thread 0 only) with thr_active = 2'b01, one clock later.
- R3: In dual mode, a halt pulse on thread 0 alone gives mode 2'b10 (thread 1 only) with thr_active = 2'b10, one clock later.
- R4: In a single-thread mode, a halt pulse from the running thread gives mode 2'b11 (sleep) with thr_active = 2'b00, one clock later.
- R5: In sleep, an interrupt pulse on one thread alone gives that thread's single-thread mode one clock later: 2'b01 for thread 0, 2'b10 for thread 1.
- R6: In a single-thread mode, an interrupt pulse to the stopped thread returns the controller to dual mode (2'b00) one clock later.
- R7: A halt to a stopped thread is ignored, and an interrupt to a running thread is ignored. The affected flag, and the mode code, keep their values.
- R8: In dual mode, halt pulses on both threads in the same cycle give sleep (2'b11) directly.
- R9: In sleep, interrupt pulses on both threads in the same cycle give dual mode (2'b00) directly.
- R10: The split flag is 1 in dual mode and 0 in both single-thread modes and in sleep.
- R11: A halt and an interrupt on the same thread in the same cycle resolve by that thread's current state: a running thread stops, and a stopped thread wakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_evt | input | 2 | Per-thread pulse: the thread executed a halt (bit n = thread n) |
| wake_irq | input | 2 | Per-thread pulse: an interrupt targets the thread (bit n = thread n) |
| mode_code | output | 2 | 00 dual, 01 thread 0 only, 10 thread 1 only, 11 sleep |
| thr_active | output | 2 | Per-thread activity flag (bit n = thread n) |
| part_split | output | 1 | 1 when partitioned resources are divided between the threads |

## Verification
The bench builds the controller with its default parameters, so the mode outputs are decoded directly from the activity flops and follow every pulse after one clock. The bench first drives each of the four modes. In each mode it then applies all sixteen combinations of halt and interrupt pulses.

This covers every transition, including the ignored pulses and the simultaneous double halt and double wake. It also covers the same-thread halt-with-interrupt collisions. The expected flags are computed arithmetically from the per-thread rule.

// File: rtl/smt_mode_pkg.sv
package smt_mode_pkg;

   localparam int unsigned THR_CNT = 2;
   localparam int unsigned CODE_W  = 2;

   typedef logic [CODE_W-1:0]  mode_t;
   typedef logic [THR_CNT-1:0] thr_vec_t;

   localparam mode_t MODE_DUAL  = 2'b00;
   localparam mode_t MODE_SOLO0 = 2'b01;
   localparam mode_t MODE_SOLO1 = 2'b10;
   localparam mode_t MODE_SLEEP = 2'b11;

endpackage

// File: rtl/smt_thread_slot.sv
module smt_thread_slot #(
   parameter bit RST_ACTIVE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_i,
   input  logic wake_i,
   output logic active_o
);

   logic active_q;
   logic active_d;

   // running thread stops on halt; stopped thread starts on interrupt
   always_comb begin
      if (active_q) active_d = ~halt_i;
      else          active_d = wake_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= RST_ACTIVE;
      else        active_q <= active_d;
   end

   assign active_o = active_q;

   // R4
   halt_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_q && halt_i |=> !active_q);

   // R5
   wake_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q && wake_i |=> active_q);

   // R7
   idle_halt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q && !wake_i |=> !active_q);

   // R7
   busy_irq_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_q && !halt_i |=> active_q);

endmodule

// File: rtl/smt_mode_encode.sv
module smt_mode_encode
   import smt_mode_pkg::*;
(
   input  thr_vec_t active_i,
   output mode_t    mode_o,
   output logic     split_o
);

   always_comb begin
      unique case (active_i)
         2'b11:   mode_o = MODE_DUAL;
         2'b01:   mode_o = MODE_SOLO0;
         2'b10:   mode_o = MODE_SOLO1;
         default: mode_o = MODE_SLEEP;
      endcase
      split_o = (mode_o == MODE_DUAL);
   end

endmodule

// File: rtl/smt_mode_ctrl.sv
module smt_mode_ctrl
   import smt_mode_pkg::*;
#(
   parameter int unsigned NUM_THR = 2,
   parameter int unsigned MODE_W  = 2,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_THR-1:0] halt_evt,
   input  logic [NUM_THR-1:0] wake_irq,
   output logic [MODE_W-1:0]  mode_code,
   output logic [NUM_THR-1:0] thr_active,
   output logic               part_split
);

   localparam int unsigned LAST_THR = NUM_THR - 1;

   initial begin
      thr_cnt_param_chk: assert (NUM_THR == THR_CNT)
         else $error("controller supports exactly %0d threads", THR_CNT);
      mode_w_param_chk: assert (MODE_W == CODE_W)
         else $error("mode code width must be %0d", CODE_W);
   end

   thr_vec_t act_w;
   mode_t    mode_w;
   logic     split_w;

   for (genvar t = 0; t <= LAST_THR; t++) begin : g_slot
      smt_thread_slot #(.RST_ACTIVE(1'b1)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .halt_i   (halt_evt[t]),
         .wake_i   (wake_irq[t]),
         .active_o (act_w[t])
      );
   end

   smt_mode_encode u_enc (
      .active_i (act_w),
      .mode_o   (mode_w),
      .split_o  (split_w)
   );

   if (REG_OUT) begin : g_reg_out
      mode_t    mode_q;
      thr_vec_t act_q;
      logic     split_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q  <= MODE_DUAL;
            act_q   <= '1;
            split_q <= 1'b1;
         end else begin
            mode_q  <= mode_w;
            act_q   <= act_w;
            split_q <= split_w;
         end
      end
      assign mode_code  = mode_q;
      assign thr_active = act_q;
      assign part_split = split_q;
   end else begin : g_comb_out
      assign mode_code  = mode_w;
      assign thr_active = act_w;
      assign part_split = split_w;
   end

   // R8
   dual_halt_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&act_w) && (&halt_evt) |=> (act_w == '0));

   // R9
   dual_wake_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_w == '0) && (&wake_irq) |=> (&act_w));

   // R10
   split_only_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      part_split |-> (mode_code == MODE_DUAL) && (&thr_active));

   // R10
   solo_recombine_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(thr_active) == 1) |-> !part_split);

endmodule

// File: tb/smt_mode_ctrl_test.sv
module smt_mode_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] halt_evt = '0;
   logic [1:0] wake_irq = '0;
   logic [1:0] mode_code;
   logic [1:0] thr_active;
   logic       part_split;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   smt_mode_ctrl uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt_evt   (halt_evt),
      .wake_irq   (wake_irq),
      .mode_code  (mode_code),
      .thr_active (thr_active),
      .part_split (part_split)
   );

   function automatic logic [1:0] mode_of(input logic [1:0] a);
      return {~a[0], ~a[1]};
   endfunction

   task automatic check(input string req, input logic [1:0] exp_a);
      checks++;
      if (thr_active !== exp_a || mode_code !== mode_of(exp_a) ||
          part_split !== (&exp_a)) begin
         fails++;
         $display("FAIL %s: act=%b mode=%b split=%b expected act=%b mode=%b split=%b",
                  req, thr_active, mode_code, part_split,
                  exp_a, mode_of(exp_a), &exp_a);
      end
   endtask

   task automatic pulse(input logic [1:0] h, input logic [1:0] w);
      @(negedge clk);
      halt_evt = h;
      wake_irq = w;
      @(negedge clk);
      halt_evt = '0;
      wake_irq = '0;
   endtask

   function automatic string tag_of(input logic [1:0] a, input logic [1:0] h,
                                    input logic [1:0] w, input logic [1:0] n);
      if ((h & w) != 2'b00)                  return "R11";
      if (n == a)                            return "R7";
      if (a == 2'b11 && n == 2'b01)          return "R2";
      if (a == 2'b11 && n == 2'b10)          return "R3";
      if (a == 2'b11 && n == 2'b00)          return "R8";
      if (a == 2'b00 && n == 2'b11)          return "R9";
      if (a == 2'b00)                        return "R5";
      if (n == 2'b11)                        return "R6";
      if (n == 2'b00)                        return "R4";
      return "R10";
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 2'b11);
      for (int s = 0; s < 4; s++) begin
         for (int c = 0; c < 16; c++) begin
            logic [1:0] st, h, w, nx;
            st = s[1:0];
            h  = c[1:0];
            w  = c[3:2];
            rst_n = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            if (st != 2'b11) begin
               pulse(~st, 2'b00);
               check(st == 2'b00 ? "R8" : (st == 2'b01 ? "R2" : "R3"), st);
            end
            for (int t = 0; t < 2; t++)
               nx[t] = st[t] ? ~h[t] : w[t];
            pulse(h, w);
            check(tag_of(st, h, w, nx), nx);
         end
      end
      // R10 R4 R6 chained walk: dual -> solo1 -> sleep -> solo0 -> dual
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      pulse(2'b01, 2'b00); check("R10", 2'b10);
      pulse(2'b10, 2'b00); check("R4",  2'b00);
      pulse(2'b00, 2'b01); check("R5",  2'b01);
      pulse(2'b00, 2'b10); check("R6",  2'b11);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: act=%b mode=%b expected completion", thr_active, mode_code);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule